// File: doc/BRIEF.md
# Power-Down and Wake-Up Sequencer

This block controls when the chip enters its power-down state and how it comes back out. A small register holds the power-down request, the entry mode, the wake-up flag and interrupt enable, the wake-up delay enable, the option to keep the low-speed crystal running, the crystal mode and the RC oscillator enables. The sequencer enters power-down on a CPU sleep indication, or at once if immediate entry is selected. It then turns off the fast oscillators and gates the system clock.

Any bit of the wake event vector ends power-down. On wake-up the block clears the power-down request and sets the wake-up flag. When the wake-up delay is enabled, it holds the system clock off for a stabilisation period whose length depends on the active clock source type. The delay counter runs on the single block clock. The source type is given on an input.

Top module: `sleep_wake_seq`

## Requirements
- R1: After reset the register reads 0x100 (only the high-speed RC enable set), `sys_clk_en` and `hrc_en` are 1, and `hxt_en`, `lxt_en`, `lrc_en`, `wake_irq` and `pd_active` are 0.
- R2: Power-down is entered on the clock edge after one where the request bit (bit 0) is 1 and either `cpu_sleep` or the immediate-entry bit (bit 1) is 1. A `cpu_sleep` while the request bit is 0 leaves the block running (idle only).
- R3: While in power-down, `sys_clk_en`, `hxt_en` and `hrc_en` are 0, and `lrc_en` follows the low-speed RC enable bit (bit 9) unchanged.
- R4: The crystal mode field (bits 7:6) selects 01 for the high-speed crystal and 10 for the low-speed crystal. Outside power-down, `hxt_en` follows mode 01 and `lxt_en` follows mode 10. In power-down, `lxt_en` stays 1 only if the mode is 10 and the keep bit (bit 5) is 1.
- R5: Any set bit of `wake_src` during power-down ends power-down on the next edge and clears the request bit. `wake_src` has no effect outside power-down.
- R6: The wake-up flag (bit 2) is set by a wake-up from power-down. Writing 1 to bit 2 clears it, and writing 0 to bit 2 leaves it unchanged.
- R7: `wake_irq` is 1 exactly while both the wake-up flag and the interrupt enable (bit 3) are 1.
- R8: With the delay enable (bit 4) set, `sys_clk_en` stays 0 after wake-up for a number of cycles set by `clk_src` at the wake edge: 4096 for 00 (crystal), 16 for 10 or 11 (high-speed RC), and none for 01 (low-speed RC). With bit 4 clear there is no delay.
- R9: A register write stores bits 0, 1 and 3 to 9 as written, and `reg_rd_data` returns the stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the delay counter clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 10 | Register write data |
| reg_rd_data | output | 10 | Register contents |
| cpu_sleep | input | 1 | CPU sleep instruction indication |
| wake_src | input | NUM_SRC | Wake event sources, one bit each |
| clk_src | input | 2 | Active clock source type |
| hxt_en | output | 1 | High-speed crystal enable |
| lxt_en | output | 1 | Low-speed crystal enable |
| hrc_en | output | 1 | High-speed RC oscillator enable |
| lrc_en | output | 1 | Low-speed RC oscillator enable |
| sys_clk_en | output | 1 | System clock gate enable |
| wake_irq | output | 1 | Wake-up interrupt |
| pd_active | output | 1 | Block is in power-down |

## Verification
The hardest case to reach is the exact end of the long crystal wake-up delay. It comes only after configuring, entering power-down, waking, and then waiting 4096 cycles with the clock gate held low. The stimulus drives this path directly and checks the gate one cycle before and at the release edge. Randomised rounds also vary the source type, delay enable, crystal mode, keep option and idle time in power-down, so that the short RC delay and the no-delay paths come up repeatedly.

// File: rtl/pws_pkg.sv
package pws_pkg;

    localparam int REG_W = 10;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_PDOWN  = 2'd1,
        ST_WDELAY = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_XTAL    = 2'd0,
        SRC_LRC     = 2'd1,
        SRC_HRC     = 2'd2,
        SRC_HRC_ALT = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        XT_OFF  = 2'd0,
        XT_HIGH = 2'd1,
        XT_LOW  = 2'd2,
        XT_EXT  = 2'd3
    } xtal_mode_e;

    // packed from bit 9 down to bit 0
    typedef struct packed {
        logic       lrc_on;
        logic       hrc_on;
        xtal_mode_e xtal;
        logic       keep_low;
        logic       dly_en;
        logic       ien;
        logic       flag;
        logic       imm;
        logic       pd_req;
    } ctrl_t;

    function automatic int unsigned wake_delay(input src_e src, input logic en,
                                               input int unsigned xd,
                                               input int unsigned hd);
        if (!en)              return 0;
        if (src == SRC_LRC)   return 0;
        if (src == SRC_XTAL)  return xd;
        return hd;
    endfunction

endpackage

// File: rtl/pws_regs.sv
module pws_regs
    import pws_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wake_hit,
    output ctrl_t            ctrl
);

    ctrl_t wv;
    ctrl_t nxt;

    assign wv = ctrl_t'(wr_data);

    always_comb begin
        nxt = ctrl;
        if (wr_en) begin
            nxt      = wv;
            nxt.flag = ctrl.flag & ~wv.flag;
        end
        if (wake_hit) begin
            nxt.pd_req = 1'b0;
            nxt.flag   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl        <= '0;
            ctrl.hrc_on <= 1'b1;
        end else begin
            ctrl <= nxt;
        end
    end

    a_r6_flag_w1c: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[2] && !wake_hit) |=> !ctrl.flag);

endmodule

// File: rtl/pws_fsm.sv
module pws_fsm
    import pws_pkg::*;
#(
    parameter int NUM_SRC  = 6,
    parameter int XTAL_DLY = 4096,
    parameter int HRC_DLY  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pd_req,
    input  logic               imm,
    input  logic               dly_en,
    input  logic               cpu_sleep,
    input  logic [NUM_SRC-1:0] wake_src,
    input  logic [1:0]         clk_src,
    output seq_state_e         state,
    output logic               wake_hit
);

    localparam int MAX_DLY = (XTAL_DLY > HRC_DLY) ? XTAL_DLY : HRC_DLY;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    logic [CNT_W-1:0] cnt;
    int unsigned      dly;
    logic             wake_any;

    assign wake_any = |wake_src;
    assign wake_hit = (state == ST_PDOWN) && wake_any;

    always_comb begin
        dly = wake_delay(src_e'(clk_src), dly_en, XTAL_DLY, HRC_DLY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (pd_req && (cpu_sleep || imm))
                        state <= ST_PDOWN;
                end
                ST_PDOWN: begin
                    if (wake_any) begin
                        if (dly == 0) begin
                            state <= ST_RUN;
                        end else begin
                            state <= ST_WDELAY;
                            cnt   <= CNT_W'(dly - 1);
                        end
                    end
                end
                ST_WDELAY: begin
                    if (cnt == '0)
                        state <= ST_RUN;
                    else
                        cnt <= cnt - 1'b1;
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    a_r8_count_down: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WDELAY && cnt != '0) |=> (state == ST_WDELAY && cnt == $past(cnt) - 1'b1));

    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WDELAY && cnt == '0) |=> state == ST_RUN);

endmodule

// File: rtl/pws_gate.sv
module pws_gate
    import pws_pkg::*;
(
    input  seq_state_e state,
    input  ctrl_t      ctrl,
    output logic       hxt_en,
    output logic       lxt_en,
    output logic       hrc_en,
    output logic       lrc_en,
    output logic       sys_clk_en
);

    logic in_pd;

    assign in_pd      = (state == ST_PDOWN);
    assign sys_clk_en = (state == ST_RUN);
    assign hxt_en     = (ctrl.xtal == XT_HIGH) && !in_pd;
    assign lxt_en     = (ctrl.xtal == XT_LOW) && (!in_pd || ctrl.keep_low);
    assign hrc_en     = ctrl.hrc_on && !in_pd;
    assign lrc_en     = ctrl.lrc_on;

endmodule

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq
    import pws_pkg::*;
#(
    parameter int NUM_SRC  = 6,
    parameter int XTAL_DLY = 4096,
    parameter int HRC_DLY  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr_en,
    input  logic [REG_W-1:0]   reg_wr_data,
    output logic [REG_W-1:0]   reg_rd_data,
    input  logic               cpu_sleep,
    input  logic [NUM_SRC-1:0] wake_src,
    input  logic [1:0]         clk_src,
    output logic               hxt_en,
    output logic               lxt_en,
    output logic               hrc_en,
    output logic               lrc_en,
    output logic               sys_clk_en,
    output logic               wake_irq,
    output logic               pd_active
);

    ctrl_t      ctrl;
    seq_state_e state;
    logic       wake_hit;

    pws_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .wake_hit (wake_hit),
        .ctrl     (ctrl)
    );

    pws_fsm #(
        .NUM_SRC  (NUM_SRC),
        .XTAL_DLY (XTAL_DLY),
        .HRC_DLY  (HRC_DLY)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pd_req    (ctrl.pd_req),
        .imm       (ctrl.imm),
        .dly_en    (ctrl.dly_en),
        .cpu_sleep (cpu_sleep),
        .wake_src  (wake_src),
        .clk_src   (clk_src),
        .state     (state),
        .wake_hit  (wake_hit)
    );

    pws_gate u_gate (
        .state      (state),
        .ctrl       (ctrl),
        .hxt_en     (hxt_en),
        .lxt_en     (lxt_en),
        .hrc_en     (hrc_en),
        .lrc_en     (lrc_en),
        .sys_clk_en (sys_clk_en)
    );

    assign reg_rd_data = ctrl;
    assign wake_irq    = ctrl.flag & ctrl.ien;
    assign pd_active   = (state == ST_PDOWN);

    a_r2_no_entry_without_req: assert property (@(posedge clk) disable iff (rst)
        (!pd_active && !reg_rd_data[0]) |=> !pd_active);

    a_r3_pd_gating: assert property (@(posedge clk) disable iff (rst)
        pd_active |-> (!sys_clk_en && !hxt_en && !hrc_en));

    a_r4_keep_low: assert property (@(posedge clk) disable iff (rst)
        (pd_active && reg_rd_data[5] && reg_rd_data[7:6] == 2'b10) |-> lxt_en);

    a_r5_req_cleared: assert property (@(posedge clk) disable iff (rst)
        (pd_active && |wake_src) |=> (!pd_active && !reg_rd_data[0]));

    a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
        (pd_active && |wake_src) |=> reg_rd_data[2]);

    a_r7_irq_needs_both: assert property (@(posedge clk) disable iff (rst)
        wake_irq |-> (reg_rd_data[2] && reg_rd_data[3]));

endmodule

// File: tb/sleep_wake_seq_test.sv
module sleep_wake_seq_test;

    localparam int NSRC = 6;

    logic            clk = 1'b0;
    logic            rst;
    logic            reg_wr_en;
    logic [9:0]      reg_wr_data;
    logic [9:0]      reg_rd_data;
    logic            cpu_sleep;
    logic [NSRC-1:0] wake_src;
    logic [1:0]      clk_src;
    logic            hxt_en, lxt_en, hrc_en, lrc_en, sys_clk_en, wake_irq, pd_active;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    sleep_wake_seq #(.NUM_SRC(NSRC), .XTAL_DLY(4096), .HRC_DLY(16)) uut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .cpu_sleep(cpu_sleep), .wake_src(wake_src),
        .clk_src(clk_src), .hxt_en(hxt_en), .lxt_en(lxt_en), .hrc_en(hrc_en),
        .lrc_en(lrc_en), .sys_clk_en(sys_clk_en), .wake_irq(wake_irq),
        .pd_active(pd_active)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // field order (bit 0 first): req, imm, flag, ien, dly, keep, xtal[1:0], hrc, lrc
    function automatic logic [9:0] pack(input logic req, input logic imm, input logic flg,
                                        input logic ien, input logic dly, input logic keep,
                                        input logic [1:0] xt, input logic hrc, input logic lrc);
        return {lrc, hrc, xt, keep, dly, ien, flg, imm, req};
    endfunction

    function automatic int exp_delay(input logic [1:0] src, input logic dly);
        if (!dly || src == 2'b01) return 0;
        if (src == 2'b00) return 4096;
        return 16;
    endfunction

    task automatic wr(input logic [9:0] d);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        tick();
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
    endtask

    task automatic wake(input logic [NSRC-1:0] w);
        wake_src = w;
        tick();
        wake_src = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0] xt, src;
        logic dly, keep, ien, lrc;
        int   d, idle;
        void'($urandom(32'd1234));
        rst = 1'b1; reg_wr_en = 0; reg_wr_data = '0; cpu_sleep = 0; wake_src = '0; clk_src = 2'b10;
        tick(2);
        rst = 1'b0;
        tick();

        // R1 reset state
        check("R1 reg", reg_rd_data, 10'h100);
        check("R1 outs", {sys_clk_en, hrc_en, hxt_en, lxt_en, lrc_en, wake_irq, pd_active}, 7'b1100000);

        // R2 idle only when request clear; R5 wake in run ignored; R6 no flag
        cpu_sleep = 1; tick(); cpu_sleep = 0;
        check("R2 idle stays run", {pd_active, sys_clk_en}, 2'b01);
        wake(6'b000100);
        check("R5 wake in run ignored", reg_rd_data[2], 1'b0);

        // R9 write/readback, R4 high crystal
        wr(pack(1, 0, 0, 1, 1, 0, 2'b01, 1, 1));
        check("R9 readback", reg_rd_data, pack(1, 0, 0, 1, 1, 0, 2'b01, 1, 1));
        check("R4 hxt on in run", {hxt_en, lxt_en}, 2'b10);
        tick(3);
        check("R2 no entry without sleep", pd_active, 1'b0);
        cpu_sleep = 1; tick(); cpu_sleep = 0;
        check("R2 entry on sleep", pd_active, 1'b1);
        check("R3 gating", {sys_clk_en, hxt_en, hrc_en, lrc_en}, 4'b0001);
        tick(5);
        check("R3 stays pd", pd_active, 1'b1);

        // R8 crystal 4096 delay, R5, R6, R7
        clk_src = 2'b00;
        wake(6'b100000);
        check("R5 left pd", {pd_active, reg_rd_data[0]}, 2'b00);
        check("R6 flag set", reg_rd_data[2], 1'b1);
        check("R7 irq", wake_irq, 1'b1);
        check("R8 held first", sys_clk_en, 1'b0);
        tick(4095);
        check("R8 held last", sys_clk_en, 1'b0);
        tick();
        check("R8 release 4096", sys_clk_en, 1'b1);

        // R2 request cleared so sleep again gives idle
        cpu_sleep = 1; tick(); cpu_sleep = 0;
        check("R2 req cleared no reentry", pd_active, 1'b0);

        // R6 write 0 keeps flag, write 1 clears
        wr(pack(0, 0, 0, 1, 1, 0, 2'b01, 1, 1));
        check("R6 w0 keeps", reg_rd_data[2], 1'b1);
        wr(pack(0, 0, 1, 0, 1, 0, 2'b01, 1, 1));
        check("R6 w1 clears", reg_rd_data[2], 1'b0);
        check("R7 irq off", wake_irq, 1'b0);

        // R2 immediate entry, R4 keep low crystal, R8 HRC 16
        wr(pack(1, 1, 0, 0, 1, 1, 2'b10, 1, 0));
        check("R4 lxt run", lxt_en, 1'b1);
        tick();
        check("R2 immediate", pd_active, 1'b1);
        check("R4 lxt kept", lxt_en, 1'b1);
        check("R7 no irq when disabled", wake_irq, 1'b0);
        clk_src = 2'b11;
        wake(6'b000001);
        tick(15);
        check("R8 hrc held", sys_clk_en, 1'b0);
        tick();
        check("R8 hrc release", sys_clk_en, 1'b1);
        check("R7 flag without enable", {reg_rd_data[2], wake_irq}, 2'b10);

        // R8 no delay when disabled
        wr(pack(1, 1, 1, 0, 0, 0, 2'b10, 1, 0));
        tick();
        check("R4 lxt off in pd", {pd_active, lxt_en}, 2'b10);
        clk_src = 2'b00;
        wake(6'b010000);
        check("R8 no delay", {pd_active, sys_clk_en}, 2'b01);

        // randomised rounds
        for (int r = 0; r < 16; r++) begin
            xt   = 2'($urandom_range(0, 3));
            src  = 2'($urandom_range(0, 3));
            dly  = 1'($urandom);
            keep = 1'($urandom);
            ien  = 1'($urandom);
            lrc  = 1'($urandom);
            if (r < 14 && src == 2'b00) src = 2'b10;
            wr(pack(1, 0, 1, ien, dly, keep, xt, 1, lrc));
            cpu_sleep = 1; tick(); cpu_sleep = 0;
            check("R2 rnd entry", pd_active, 1'b1);
            check("R3 rnd gating", {sys_clk_en, hxt_en, hrc_en, lrc_en}, {3'b000, lrc});
            check("R4 rnd lxt", lxt_en, (xt == 2'b10) && keep);
            idle = $urandom_range(0, 5);
            tick(idle);
            check("R3 rnd stays", pd_active, 1'b1);
            clk_src = src;
            wake(NSRC'($urandom_range(1, (1 << NSRC) - 1)));
            d = exp_delay(src, dly);
            check("R6 rnd flag", reg_rd_data[2], 1'b1);
            check("R7 rnd irq", wake_irq, ien);
            check("R4 rnd hxt", hxt_en, xt == 2'b01);
            if (d == 0) begin
                check("R8 rnd no delay", sys_clk_en, 1'b1);
            end else begin
                tick(d - 1);
                check("R8 rnd held", sys_clk_en, 1'b0);
                tick();
                check("R8 rnd release", sys_clk_en, 1'b1);
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule